// File: doc/BRIEF.md
# Video Line Doubler with Per-Line Resync

This block turns a 15 kHz progressive pixel stream into one with twice the line rate, suitable for a VGA-class monitor. It runs on a single clock at twice the dot rate. An input-sample enable marks every other cycle as a dot-rate sample. Each incoming line is written into one half of a ping-pong line buffer. The line captured before it is read from the other half twice, back to back, at the full clock rate.

Each input line captures a fixed number of samples. The write position restarts at every rising input hsync. A source whose line total is a few samples short or long therefore shifts pixels at the right edge. It never drifts out of sync. The output is forced to zero outside the active window, during output vsync and before the first full line is buffered. An optional scanline mode blanks the second copy of every line. The output hsync is generated locally, and every second output line starts in lock with the input line start.

Top module: `line_doubler`

## Requirements
- R1: With LINE_LEN output cycles per output line, output position p of both copies of a line shows input sample p of the previously captured line. Sample 0 is the sample at which the hsync rise is seen.
- R2: A rising hs_in seen on an enabled sample restarts capture at address 0. Samples beyond LINE_LEN in a long line are dropped. The line after a short or long line is still aligned at position 0.
- R3: pix_out is zero at every output position outside [ACT_START, ACT_START+ACT_LEN).
- R4: hs_out is at level HS_POL for output positions 0 to HS_LEN-1 of each output line and at the opposite level otherwise. Position 0 of the first copy appears two clock edges after the edge that samples the input hsync rise.
- R5: vs_out carries the vs_in level sampled at the start of the previous input line. It changes only at an input line start, so pulse lengths in lines are kept.
- R6: pix_out is zero while vs_out is high.
- R7: With scanline_en high, the second copy of each line is all zero. With it low, both copies carry the same pixels.
- R8: During reset, pix_out and vs_out are 0 and hs_out is inactive. pix_out stays zero until one complete input line has been captured after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the dot rate |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_ce | input | 1 | Input-sample enable, high every other cycle |
| pix_in | input | PIX_W | Input pixel (RGBI by default) |
| hs_in | input | 1 | Input hsync, active high |
| vs_in | input | 1 | Input vsync, active high |
| scanline_en | input | 1 | Blank the second copy of each line |
| pix_out | output | PIX_W | Doubled-rate pixel output |
| hs_out | output | 1 | Output hsync, level set by HS_POL |
| vs_out | output | 1 | Output vsync, delayed by one input line |

## Verification
The assertions assume the following about the inputs:
- pix_ce is high on at most every other cycle.
- hs_in is low while reset is applied.
- scanline_en changes only at line boundaries.
- A line is long enough that its last samples fall outside the active window.

The bench keeps within these bounds. It drives pix_ce on alternate cycles and holds scanline_en fixed across each whole line. It changes hs_in, vs_in and the pixel only on enabled samples. Line lengths of LINE_LEN, LINE_LEN-4 and LINE_LEN+6 are sent, all longer than the active window's end.

// File: rtl/lndbl_pkg.sv
package lndbl_pkg;

   // Which of the two readouts of a buffered line is being emitted.
   typedef enum logic {
      REP_FIRST  = 1'b0,
      REP_SECOND = 1'b1
   } rep_e;

   // Buffer half selector.
   typedef logic bank_t;

endpackage

// File: rtl/lndbl_capture.sv
module lndbl_capture
   import lndbl_pkg::*;
#(
   parameter int LINE_LEN = 1024,
   parameter int AW       = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pix_ce,
   input  logic          hs_in,
   input  logic          vs_in,
   output logic          line_start,
   output logic          wr_en,
   output bank_t         wr_bank,
   output logic [AW-1:0] wr_addr,
   output bank_t         fill_bank,
   output logic          vs_line,
   output logic          have_line
);

   localparam int CW = AW + 1;
   localparam logic [CW-1:0] CNT_MAX = CW'(LINE_LEN);

   logic          hs_prev;
   logic [CW-1:0] wr_cnt;
   bank_t         bank_q;
   logic          vs_q;
   logic          started_q;

   assign line_start = rst_n & pix_ce & hs_in & ~hs_prev;
   assign wr_en      = pix_ce & (line_start | (wr_cnt < CNT_MAX));
   assign wr_bank    = line_start ? ~bank_q : bank_q;
   assign wr_addr    = line_start ? '0 : wr_cnt[AW-1:0];
   assign fill_bank  = bank_q;
   assign vs_line    = vs_q;
   assign have_line  = started_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hs_prev   <= 1'b0;
         wr_cnt    <= CNT_MAX;
         bank_q    <= 1'b0;
         vs_q      <= 1'b0;
         started_q <= 1'b0;
      end else if (pix_ce) begin
         hs_prev <= hs_in;
         if (line_start) begin
            bank_q    <= ~bank_q;
            wr_cnt    <= CW'(1);
            vs_q      <= vs_in;
            started_q <= 1'b1;
         end else if (wr_cnt < CNT_MAX) begin
            wr_cnt <= wr_cnt + CW'(1);
         end
      end
   end

   // R2: a new line always resumes writing right after address 0
   a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |=> (wr_cnt == CW'(1)));
   // R2: writing never runs past the fixed sample count
   a_r2_truncate: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt <= CNT_MAX);

endmodule

// File: rtl/lndbl_linebuf.sv
module lndbl_linebuf
   import lndbl_pkg::*;
#(
   parameter int PIX_W = 4,
   parameter int DEPTH = 1024,
   parameter int AW    = 10
) (
   input  logic             clk,
   input  logic             wr_en,
   input  bank_t            wr_bank,
   input  logic [AW-1:0]    wr_addr,
   input  logic [PIX_W-1:0] wr_data,
   input  bank_t            rd_bank,
   input  logic [AW-1:0]    rd_addr,
   output logic [PIX_W-1:0] rd_data
);

   logic [PIX_W-1:0] rd_word [2];

   for (genvar b = 0; b < 2; b++) begin : g_half
      logic [PIX_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && (wr_bank == 1'(b)))
            mem[wr_addr] <= wr_data;
      end

      assign rd_word[b] = mem[rd_addr];
   end

   assign rd_data = rd_word[rd_bank];

endmodule

// File: rtl/lndbl_readout.sv
module lndbl_readout
   import lndbl_pkg::*;
#(
   parameter int PIX_W     = 4,
   parameter int LINE_LEN  = 1024,
   parameter int AW        = 10,
   parameter int ACT_START = 160,
   parameter int ACT_LEN   = 800,
   parameter int HS_LEN    = 60,
   parameter bit HS_POL    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_start,
   input  bank_t            fill_bank,
   input  logic             vs_line,
   input  logic             have_line,
   input  logic             scanline_en,
   input  logic [PIX_W-1:0] rd_data,
   output logic [AW-1:0]    rd_addr,
   output bank_t            rd_bank,
   output logic [PIX_W-1:0] pix_out,
   output logic             hs_out,
   output logic             vs_out
);

   localparam logic [AW:0]   WIN_LO  = (AW+1)'(ACT_START);
   localparam logic [AW:0]   WIN_HI  = (AW+1)'(ACT_START + ACT_LEN);
   localparam logic [AW:0]   SYNC_HI = (AW+1)'(HS_LEN);
   localparam logic [AW-1:0] LAST    = AW'(LINE_LEN - 1);

   logic [AW-1:0] rd_cnt;
   rep_e          rep;
   bank_t         bank_q;
   logic          vs_q;
   logic          ok_q;
   logic          in_win;
   logic          sync_act;
   logic          hs_next;
   logic          show;

   assign in_win   = ({1'b0, rd_cnt} >= WIN_LO) && ({1'b0, rd_cnt} < WIN_HI);
   assign sync_act = {1'b0, rd_cnt} < SYNC_HI;
   assign show     = ok_q & ~vs_q & in_win & ~(scanline_en & (rep == REP_SECOND));

   if (HS_POL) begin : g_hs_high
      assign hs_next = sync_act;
   end else begin : g_hs_low
      assign hs_next = ~sync_act;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_cnt  <= '0;
         rep     <= REP_FIRST;
         bank_q  <= 1'b1;
         vs_q    <= 1'b0;
         ok_q    <= 1'b0;
         pix_out <= '0;
         hs_out  <= ~HS_POL;
      end else begin
         if (line_start) begin
            rd_cnt <= '0;
            rep    <= REP_FIRST;
            bank_q <= fill_bank;
            vs_q   <= vs_line;
            ok_q   <= have_line;
         end else if (rd_cnt == LAST) begin
            rd_cnt <= '0;
            rep    <= (rep == REP_FIRST) ? REP_SECOND : REP_FIRST;
         end else begin
            rd_cnt <= rd_cnt + AW'(1);
         end
         pix_out <= show ? rd_data : '0;
         hs_out  <= hs_next;
      end
   end

   assign rd_addr = rd_cnt;
   assign rd_bank = bank_q;
   assign vs_out  = vs_q;

   // R4: the output line counter restarts with the input line
   a_r4_hs_lock: assert property (@(posedge clk) disable iff (!rst_n)
      $past(line_start, 2) |-> (hs_out == HS_POL));
   // R5: vertical sync moves only at input line starts
   a_r5_vs_steady: assert property (@(posedge clk) disable iff (!rst_n)
      !line_start |=> $stable(vs_out));
   // R7: second copy blanked in scanline mode
   a_r7_scanline: assert property (@(posedge clk) disable iff (!rst_n)
      (scanline_en && rep == REP_SECOND) |=> (pix_out == '0));
   // R3: left blanking region stays black
   a_r3_left_blank: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, rd_cnt} < WIN_LO) |=> (pix_out == '0));
   // R8: black until a whole line is buffered
   a_r8_no_line: assert property (@(posedge clk) disable iff (!rst_n)
      !ok_q |=> (pix_out == '0));
   // R6: black throughout output vsync
   a_r6_vs_black: assert property (@(posedge clk) disable iff (!rst_n)
      (vs_q && !line_start) |=> (pix_out == '0));

endmodule

// File: rtl/line_doubler.sv
module line_doubler
   import lndbl_pkg::*;
#(
   parameter int PIX_W     = 4,
   parameter int LINE_LEN  = 1024,
   parameter int ACT_START = 160,
   parameter int ACT_LEN   = 800,
   parameter int HS_LEN    = 60,
   parameter bit HS_POL    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_ce,
   input  logic [PIX_W-1:0] pix_in,
   input  logic             hs_in,
   input  logic             vs_in,
   input  logic             scanline_en,
   output logic [PIX_W-1:0] pix_out,
   output logic             hs_out,
   output logic             vs_out
);

   localparam int AW = (LINE_LEN <= 2) ? 1 : $clog2(LINE_LEN);

   if (LINE_LEN < 4) begin : g_chk_len
      $error("line_doubler: LINE_LEN must be at least 4");
   end
   if (ACT_START + ACT_LEN > LINE_LEN) begin : g_chk_win
      $error("line_doubler: active window exceeds line length");
   end
   if (HS_LEN < 1 || HS_LEN >= LINE_LEN) begin : g_chk_hs
      $error("line_doubler: HS_LEN out of range");
   end
   if (PIX_W < 1) begin : g_chk_pix
      $error("line_doubler: PIX_W must be positive");
   end

   logic          line_start;
   logic          wr_en;
   bank_t         wr_bank;
   logic [AW-1:0] wr_addr;
   bank_t         fill_bank;
   logic          vs_line;
   logic          have_line;
   logic [AW-1:0] rd_addr;
   bank_t         rd_bank;
   logic [PIX_W-1:0] rd_data;

   lndbl_capture #(
      .LINE_LEN (LINE_LEN),
      .AW       (AW)
   ) u_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .pix_ce     (pix_ce),
      .hs_in      (hs_in),
      .vs_in      (vs_in),
      .line_start (line_start),
      .wr_en      (wr_en),
      .wr_bank    (wr_bank),
      .wr_addr    (wr_addr),
      .fill_bank  (fill_bank),
      .vs_line    (vs_line),
      .have_line  (have_line)
   );

   lndbl_linebuf #(
      .PIX_W (PIX_W),
      .DEPTH (LINE_LEN),
      .AW    (AW)
   ) u_linebuf (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_bank (wr_bank),
      .wr_addr (wr_addr),
      .wr_data (pix_in),
      .rd_bank (rd_bank),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   lndbl_readout #(
      .PIX_W     (PIX_W),
      .LINE_LEN  (LINE_LEN),
      .AW        (AW),
      .ACT_START (ACT_START),
      .ACT_LEN   (ACT_LEN),
      .HS_LEN    (HS_LEN),
      .HS_POL    (HS_POL)
   ) u_readout (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_start  (line_start),
      .fill_bank   (fill_bank),
      .vs_line     (vs_line),
      .have_line   (have_line),
      .scanline_en (scanline_en),
      .rd_data     (rd_data),
      .rd_addr     (rd_addr),
      .rd_bank     (rd_bank),
      .pix_out     (pix_out),
      .hs_out      (hs_out),
      .vs_out      (vs_out)
   );

   // R1: the half being read is never the one being filled
   a_r1_bank_split: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !line_start) |-> (wr_bank != rd_bank));

endmodule

// File: tb/line_doubler_tb.sv
module line_doubler_tb;

   localparam int N     = 64;
   localparam int AS    = 12;
   localparam int AL    = 40;
   localparam int HSL   = 6;
   localparam int PW    = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          pix_ce;
   logic [PW-1:0] pix_in;
   logic          hs_in;
   logic          vs_in;
   logic          scanline_en;
   logic [PW-1:0] pix_out;
   logic          hs_out;
   logic          vs_out;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   int prev_idx   = 0;
   int prev_len   = 0;
   bit prev_vs    = 1'b0;
   int lines_done = 0;

   always #5 clk = ~clk;

   line_doubler #(
      .PIX_W     (PW),
      .LINE_LEN  (N),
      .ACT_START (AS),
      .ACT_LEN   (AL),
      .HS_LEN    (HSL),
      .HS_POL    (1'b1)
   ) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .pix_ce      (pix_ce),
      .pix_in      (pix_in),
      .hs_in       (hs_in),
      .vs_in       (vs_in),
      .scanline_en (scanline_en),
      .pix_out     (pix_out),
      .hs_out      (hs_out),
      .vs_out      (vs_out)
   );

   function automatic logic [PW-1:0] fpix(int l, int p);
      return PW'((p * 7 + l * 3 + 1) % 16);
   endfunction

   task automatic expect_bit(string tag, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %0b expected %0b", tag, what, act, exp);
      end
   endtask

   // k: output cycles since the first output position of the current line pair
   task automatic chk(int k);
      int pos = k % N;
      int rep = (k / N) % 2;
      bit inwin = (pos >= AS) && (pos < AS + AL);
      bit valid = (lines_done >= 1);
      logic [PW-1:0] exp_pix;
      string tag;
      if (!valid)                             tag = "R8";
      else if (prev_vs)                       tag = "R6";
      else if (!inwin)                        tag = "R3";
      else if (scanline_en && rep == 1)       tag = "R7";
      else if (prev_len != N)                 tag = "R2";
      else                                    tag = "R1";
      exp_pix = (valid && !prev_vs && inwin && !(scanline_en && rep == 1))
                ? fpix(prev_idx, pos) : '0;
      checks++;
      if (pix_out !== exp_pix) begin
         errors++;
         $display("FAIL %s pix k=%0d actual %0h expected %0h", tag, k, pix_out, exp_pix);
      end
      expect_bit("R4", "hs_out", hs_out, (pos < HSL));
      expect_bit("R5", "vs_out", vs_out, prev_vs);
   endtask

   task automatic send_line(int idx, int len, bit vs);
      for (int s = 0; s < len; s++) begin
         @(negedge clk);
         if (s > 0) chk(2 * s - 2);
         pix_ce = 1'b1;
         pix_in = fpix(idx, s);
         hs_in  = (s < 4);
         vs_in  = vs;
         @(negedge clk);
         if (s > 0) chk(2 * s - 1);
         pix_ce = 1'b0;
      end
      prev_idx = idx;
      prev_len = len;
      prev_vs  = vs;
      lines_done++;
   endtask

   initial begin
      rst_n       = 1'b0;
      pix_ce      = 1'b0;
      pix_in      = '0;
      hs_in       = 1'b0;
      vs_in       = 1'b0;
      scanline_en = 1'b0;
      repeat (4) @(negedge clk);
      // R8: reset state
      expect_bit("R8", "reset pix zero", (pix_out == '0), 1'b1);
      expect_bit("R8", "reset vs_out", vs_out, 1'b0);
      expect_bit("R8", "reset hs_out", hs_out, 1'b0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      send_line(0,  N,     1'b0);  // R8: nothing shown yet
      send_line(1,  N,     1'b0);  // R1: line 0 doubled
      send_line(2,  N - 4, 1'b0);  // R1: line 1
      scanline_en = 1'b1;
      send_line(3,  N,     1'b0);  // R2/R7: short line 2, scanlines
      send_line(4,  N + 6, 1'b0);  // R7: line 3, long input line
      scanline_en = 1'b0;
      send_line(5,  N,     1'b1);  // R2: truncated line 4 aligned
      send_line(6,  N,     1'b1);  // R5/R6: vsync delayed one line
      send_line(7,  N,     1'b0);  // R6: still blanked
      send_line(8,  N - 4, 1'b0);  // R1: vsync released
      scanline_en = 1'b1;
      send_line(9,  N,     1'b0);  // R7: short line 8 with scanlines
      scanline_en = 1'b0;
      send_line(10, N,     1'b0);  // R1: line 9 both copies

      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog expired actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule